// File: doc/BRIEF.md
# Serial LDPC Parity Accumulator

This block is the parity engine of a systematic LDPC encoder of the irregular-repeat-accumulate family. Information bits arrive one per beat on a valid/ready stream. Each accepted bit is stored. The bit is then folded into a parity register array once for every entry in the address row that belongs to its group, at a rate of one XOR per clock. Each address is shifted by the bit's position inside its group, so consecutive bits of a group land on different parity positions.

When the closing beat of the frame has been absorbed, a chain pass runs over the parity array. This pass makes every parity bit the running XOR of itself and all lower-indexed bits. The block then plays the codeword out: first the stored information bits, then the parity bits, with a marker on the final beat. The input side stays closed until the whole codeword has left.

The cost per information bit equals the length of its table row. The address table in this configuration has long rows first and a short row at the end. As a result, the accept rate rises in the last group of every frame. The width of the data path has no part in this.

Top module: `ldpc_ira_encoder`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, no output beat is offered (`m_valid` low) and the input is not ready.
- R2: The code has K = 24 information bits in three groups of G = 8 bits, and P = 16 parity bits (step q = P/G = 2). Row 0 holds addresses {3, 7, 12, 0}, row 1 holds {5, 9, 14, 1} and row 2 holds {2, 11}. Information bit b uses row b/G. For each address x in that row, the bit is XORed into parity bit (x + (b mod G)·q) mod P.
- R3: After the last information bit has been accumulated, parity bit i is replaced by p[i] XOR p[i−1], in order for i = 1 up to P−1. Each step uses the already-updated lower bit.
- R4: With `s_valid` held high, the block accepts a new bit exactly L cycles after the previous one, where L is the row length of the previous bit. That is 4 cycles in groups 0 and 1, and 2 cycles in group 2.
- R5: No output beat is offered before the input beat carrying `s_last` has been accepted. `s_ready` stays low from that beat until the codeword's final beat has been accepted.
- R6: The codeword is sent as K information bits in arrival order, followed by parity bits 0 to P−1. `m_last` is high on beat K+P−1 only.
- R7: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_last` hold their values.
- R8: Gaps in `s_valid` inside a frame neither drop nor repeat information bits.
- R9: The parity array starts from all zeros for every frame. A frame's parity does not depend on the frames before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Information bit offered |
| s_ready | output | 1 | Block can take an information bit |
| s_data | input | 1 | Information bit |
| s_last | input | 1 | Marks the K-th information bit of a frame |
| m_valid | output | 1 | Codeword bit offered |
| m_ready | input | 1 | Downstream accepts the codeword bit |
| m_data | output | 1 | Codeword bit |
| m_last | output | 1 | Marks the final codeword bit |

## Verification
The assertions assume that every input frame is exactly K bits long and that `s_last` is raised on the K-th bit and on no other. Under that assumption, the pacing check can derive each bit's row from a simple beat count. The stimulus always sends complete K-bit frames with the marker in place, and it varies only the data and the stall patterns on `s_valid` and `m_ready`. Both stall patterns are drawn at random and are unconstrained otherwise.

// File: rtl/ldpc_pkg.sv
`timescale 1ns/1ps
package ldpc_pkg;

  // Small test code: three groups of eight bits, sixteen parity bits.
  localparam int PKG_GROUP  = 8;
  localparam int PKG_NROWS  = 3;
  localparam int PKG_PAR    = 16;
  localparam int PKG_MAXLEN = 4;

  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_ACC   = 2'd1,
    ST_CHAIN = 2'd2,
    ST_OUT   = 2'd3
  } enc_state_e;

  // Number of parity addresses held by a row.
  function automatic int row_len(input int r);
    case (r)
      0:       row_len = 4;
      1:       row_len = 4;
      2:       row_len = 2;
      default: row_len = 0;
    endcase
  endfunction

  // Base parity address at entry e of row r.
  function automatic int row_addr(input int r, input int e);
    row_addr = 0;
    case (r)
      0: case (e) 0: row_addr = 3; 1: row_addr = 7; 2: row_addr = 12; default: row_addr = 0; endcase
      1: case (e) 0: row_addr = 5; 1: row_addr = 9; 2: row_addr = 14; default: row_addr = 1; endcase
      2: case (e) 0: row_addr = 2; default: row_addr = 11; endcase
      default: row_addr = 0;
    endcase
  endfunction

endpackage

// File: rtl/ldpc_addr_gen.sv
`timescale 1ns/1ps
module ldpc_addr_gen
  import ldpc_pkg::*;
#(
  parameter int GROUP    = PKG_GROUP,
  parameter int PAR_BITS = PKG_PAR,
  parameter int RW       = 2,
  parameter int EW       = 2,
  parameter int MW       = 3,
  parameter int AW       = 4
) (
  input  logic [RW-1:0] row,
  input  logic [EW-1:0] entry,
  input  logic [MW-1:0] pos,
  output logic [AW-1:0] addr
);
  localparam int STEP = PAR_BITS / GROUP;

  int sum;

  // Base address plus position offset. Both terms are below P, so one
  // conditional subtract completes the modulo.
  always_comb begin
    sum = row_addr(int'(row), int'(entry)) + int'(pos) * STEP;
    if (sum >= PAR_BITS) sum = sum - PAR_BITS;
    addr = AW'(sum);
  end
endmodule

// File: rtl/ldpc_parity_mem.sv
`timescale 1ns/1ps
module ldpc_parity_mem #(
  parameter int PAR_BITS = 16,
  parameter int AW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tog_en,
  input  logic [AW-1:0] tog_addr,
  input  logic          tog_bit,
  input  logic          chn_en,
  input  logic [AW-1:0] chn_idx,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit
);
  logic [PAR_BITS-1:0] mem_q;
  logic [PAR_BITS-1:0] mem_d;

  for (genvar i = 0; i < PAR_BITS; i++) begin : g_cell
    logic hit_tog;
    logic hit_chn;
    always_comb begin
      hit_tog = tog_en && (tog_addr == AW'(i)) && tog_bit;
      hit_chn = chn_en && (chn_idx == AW'(i));
    end
    if (i == 0) begin : g_first
      always_comb mem_d[i] = clr ? 1'b0 : (mem_q[i] ^ hit_tog);
    end else begin : g_rest
      always_comb mem_d[i] = clr ? 1'b0 : (mem_q[i] ^ hit_tog ^ (hit_chn & mem_q[i-1]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else        mem_q <= mem_d;
  end

  assign rd_bit = mem_q[rd_addr];
endmodule

// File: rtl/ldpc_info_store.sv
`timescale 1ns/1ps
module ldpc_info_store #(
  parameter int INFO_BITS = 24,
  parameter int KW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [KW-1:0] waddr,
  input  logic          wbit,
  input  logic [KW-1:0] raddr,
  output logic          rbit
);
  logic [INFO_BITS-1:0] buf_q;
  logic [INFO_BITS-1:0] buf_d;

  for (genvar i = 0; i < INFO_BITS; i++) begin : g_slot
    always_comb buf_d[i] = (we && (waddr == KW'(i))) ? wbit : buf_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_q <= '0;
    else        buf_q <= buf_d;
  end

  assign rbit = buf_q[raddr];
endmodule

// File: rtl/ldpc_ira_encoder.sv
`timescale 1ns/1ps
module ldpc_ira_encoder
  import ldpc_pkg::*;
#(
  parameter int GROUP    = PKG_GROUP,
  parameter int NROWS    = PKG_NROWS,
  parameter int PAR_BITS = PKG_PAR,
  parameter int MAX_LEN  = PKG_MAXLEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_valid,
  output logic s_ready,
  input  logic s_data,
  input  logic s_last,
  output logic m_valid,
  input  logic m_ready,
  output logic m_data,
  output logic m_last
);
  localparam int INFO_BITS  = GROUP * NROWS;
  localparam int FRAME_BITS = INFO_BITS + PAR_BITS;
  localparam int AW = $clog2(PAR_BITS);
  localparam int KW = $clog2(INFO_BITS);
  localparam int OW = $clog2(FRAME_BITS);
  localparam int MW = (GROUP > 1) ? $clog2(GROUP) : 1;
  localparam int RW = $clog2(NROWS + 1);
  localparam int EW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  enc_state_e    st_q, st_d;
  logic          busy_q, busy_d;
  logic [EW-1:0] entry_q, entry_d;
  logic          cbit_q, cbit_d;
  logic          clast_q, clast_d;
  logic [MW-1:0] cpos_q, cpos_d;
  logic [RW-1:0] crow_q, crow_d;
  logic [MW-1:0] npos_q, npos_d;
  logic [RW-1:0] nrow_q, nrow_d;
  logic [KW-1:0] widx_q, widx_d;
  logic [AW-1:0] chn_q, chn_d;
  logic [OW-1:0] ocnt_q, ocnt_d;

  logic          mem_clr, tog_en, chn_en, info_we;
  logic [AW-1:0] tog_addr;
  logic          par_bit, info_bit;
  logic          last_entry, accept, is_info;
  int            cur_len;

  ldpc_addr_gen #(
    .GROUP(GROUP), .PAR_BITS(PAR_BITS), .RW(RW), .EW(EW), .MW(MW), .AW(AW)
  ) u_addr (
    .row(crow_q), .entry(entry_q), .pos(cpos_q), .addr(tog_addr)
  );

  ldpc_parity_mem #(.PAR_BITS(PAR_BITS), .AW(AW)) u_par (
    .clk(clk), .rst_n(rst_n), .clr(mem_clr),
    .tog_en(tog_en), .tog_addr(tog_addr), .tog_bit(cbit_q),
    .chn_en(chn_en), .chn_idx(chn_q),
    .rd_addr(AW'(ocnt_q - OW'(INFO_BITS))), .rd_bit(par_bit)
  );

  ldpc_info_store #(.INFO_BITS(INFO_BITS), .KW(KW)) u_info (
    .clk(clk), .rst_n(rst_n), .we(info_we), .waddr(widx_q), .wbit(s_data),
    .raddr(KW'(ocnt_q)), .rbit(info_bit)
  );

  always_comb begin
    cur_len    = row_len(int'(crow_q));
    last_entry = busy_q && (int'(entry_q) == cur_len - 1);
    is_info    = int'(ocnt_q) < INFO_BITS;
    m_data     = is_info ? info_bit : par_bit;
  end

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    busy_d  = busy_q;
    entry_d = entry_q;
    cbit_d  = cbit_q;
    clast_d = clast_q;
    cpos_d  = cpos_q;
    crow_d  = crow_q;
    npos_d  = npos_q;
    nrow_d  = nrow_q;
    widx_d  = widx_q;
    chn_d   = chn_q;
    ocnt_d  = ocnt_q;
    mem_clr = 1'b0;
    tog_en  = 1'b0;
    chn_en  = 1'b0;
    info_we = 1'b0;
    s_ready = 1'b0;
    m_valid = 1'b0;
    m_last  = 1'b0;
    accept  = 1'b0;

    case (st_q)
      ST_CLEAR: begin
        mem_clr = 1'b1;
        busy_d  = 1'b0;
        entry_d = '0;
        clast_d = 1'b0;
        npos_d  = '0;
        nrow_d  = '0;
        widx_d  = '0;
        st_d    = ST_ACC;
      end

      ST_ACC: begin
        s_ready = !clast_q && (!busy_q || last_entry);
        accept  = s_valid && s_ready;
        tog_en  = busy_q;
        if (busy_q) begin
          if (last_entry) begin
            busy_d  = 1'b0;
            entry_d = '0;
            if (clast_q) begin
              st_d  = ST_CHAIN;
              chn_d = AW'(1);
            end
          end else begin
            entry_d = entry_q + 1'b1;
          end
        end
        if (accept) begin
          busy_d  = 1'b1;
          entry_d = '0;
          cbit_d  = s_data;
          clast_d = s_last;
          cpos_d  = npos_q;
          crow_d  = nrow_q;
          info_we = 1'b1;
          widx_d  = widx_q + 1'b1;
          if (int'(npos_q) == GROUP - 1) begin
            npos_d = '0;
            nrow_d = nrow_q + 1'b1;
          end else begin
            npos_d = npos_q + 1'b1;
          end
        end
      end

      ST_CHAIN: begin
        chn_en = 1'b1;
        if (int'(chn_q) == PAR_BITS - 1) begin
          st_d   = ST_OUT;
          ocnt_d = '0;
        end else begin
          chn_d = chn_q + 1'b1;
        end
      end

      ST_OUT: begin
        m_valid = 1'b1;
        m_last  = (int'(ocnt_q) == FRAME_BITS - 1);
        if (m_ready) begin
          if (m_last) st_d = ST_CLEAR;
          else        ocnt_d = ocnt_q + 1'b1;
        end
      end

      default: st_d = ST_CLEAR;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_CLEAR;
      busy_q  <= 1'b0;
      entry_q <= '0;
      cbit_q  <= 1'b0;
      clast_q <= 1'b0;
      cpos_q  <= '0;
      crow_q  <= '0;
      npos_q  <= '0;
      nrow_q  <= '0;
      widx_q  <= '0;
      chn_q   <= '0;
      ocnt_q  <= '0;
    end else begin
      st_q    <= st_d;
      busy_q  <= busy_d;
      entry_q <= entry_d;
      cbit_q  <= cbit_d;
      clast_q <= clast_d;
      cpos_q  <= cpos_d;
      crow_q  <= crow_d;
      npos_q  <= npos_d;
      nrow_q  <= nrow_d;
      widx_q  <= widx_d;
      chn_q   <= chn_d;
      ocnt_q  <= ocnt_d;
    end
  end
endmodule

module ldpc_ira_encoder_chk
  import ldpc_pkg::*;
#(
  parameter int GROUP    = PKG_GROUP,
  parameter int NROWS    = PKG_NROWS,
  parameter int PAR_BITS = PKG_PAR
) (
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_ready,
  input logic s_last,
  input logic m_valid,
  input logic m_ready,
  input logic m_data,
  input logic m_last
);
  localparam int INFO  = GROUP * NROWS;
  localparam int FRAME = INFO + PAR_BITS;

  int   in_cnt, out_cnt, gap, prev_len;
  logic seen_last, have_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cnt    <= 0;
      out_cnt   <= 0;
      gap       <= 0;
      prev_len  <= 0;
      seen_last <= 1'b0;
      have_prev <= 1'b0;
    end else begin
      if (s_valid && s_ready) begin
        in_cnt    <= s_last ? 0 : in_cnt + 1;
        gap       <= 1;
        prev_len  <= row_len(in_cnt / GROUP);
        have_prev <= !s_last;
        if (s_last) seen_last <= 1'b1;
      end else if (gap < 1000) begin
        gap <= gap + 1;
      end
      if (m_valid && m_ready) begin
        out_cnt <= m_last ? 0 : out_cnt + 1;
        if (m_last) seen_last <= 1'b0;
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> !m_valid && !s_ready); // R1
  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && s_last |-> in_cnt == INFO - 1); // R5
  AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> seen_last); // R5
  AST_IN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !s_ready); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last)); // R7
  AST_LAST_POS: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_last == (out_cnt == FRAME - 1))); // R6
  AST_BIT_PACING: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready && have_prev |-> gap >= prev_len); // R4
endmodule

bind ldpc_ira_encoder ldpc_ira_encoder_chk #(
  .GROUP(GROUP), .NROWS(NROWS), .PAR_BITS(PAR_BITS)
) u_chk (.*);

// File: tb/ldpc_ira_encoder_bench.sv
`timescale 1ns/1ps
module ldpc_ira_encoder_bench;
  localparam int G = 8;
  localparam int K = 24;
  localparam int P = 16;
  localparam int Q = P / G;

  logic clk, rst_n;
  logic s_valid, s_ready, s_data, s_last;
  logic m_valid, m_ready, m_data, m_last;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  int             acc_cyc [K];
  logic [K+P-1:0] obits;
  int             nlast, last_pos, first_out, hold_bad, rdy_bad;

  ldpc_ira_encoder u_ldpc_ira_encoder (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int tb_len(input int r);
    return (r == 2) ? 2 : 4;
  endfunction

  function automatic int tb_addr(input int r, input int e);
    int t0 [4] = '{3, 7, 12, 0};
    int t1 [4] = '{5, 9, 14, 1};
    int t2 [2] = '{2, 11};
    if (r == 0) return t0[e];
    if (r == 1) return t1[e];
    return t2[e];
  endfunction

  function automatic logic [P-1:0] ref_par(input logic [K-1:0] fr);
    logic [P-1:0] p = '0;
    for (int b = 0; b < K; b++) begin
      for (int e = 0; e < tb_len(b / G); e++) begin
        int a = (tb_addr(b / G, e) + (b % G) * Q) % P;
        p[a] = p[a] ^ fr[b];
      end
    end
    for (int i = 1; i < P; i++) p[i] = p[i] ^ p[i-1];
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc == 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      summary();
    end
  end

  task automatic run_frame(input logic [K-1:0] fr, input int vst, input int rst_pct);
    nlast = 0; last_pos = -1; first_out = -1; hold_bad = 0; rdy_bad = 0;
    obits = '0;
    fork
      begin
        int b = 0;
        while (b < K) begin
          @(negedge clk);
          s_valid = (($urandom % 100) >= vst);
          s_data  = fr[b];
          s_last  = (b == K - 1);
          #2;
          if (s_valid && s_ready) begin
            acc_cyc[b] = cyc;
            b++;
          end
        end
        @(negedge clk);
        s_valid = 1'b0;
        s_last  = 1'b0;
      end
      begin
        int   o = 0;
        bit   done = 0;
        bit   hold = 0;
        logic hd = 1'b0;
        while (!done) begin
          @(negedge clk);
          m_ready = (($urandom % 100) >= rst_pct);
          #2;
          if (m_valid && s_ready) rdy_bad++;
          if (hold && !(m_valid && m_data == hd)) hold_bad++;
          if (m_valid && first_out < 0) first_out = cyc;
          hold = m_valid && !m_ready;
          hd   = m_data;
          if (m_valid && m_ready) begin
            if (o < K + P) obits[o] = m_data;
            if (m_last) begin
              nlast++;
              last_pos = o;
              done = 1;
            end
            o++;
          end
        end
        @(negedge clk);
        m_ready = 1'b0;
      end
    join
  endtask

  task automatic check_frame(input logic [K-1:0] fr, input string preq, input bit pace);
    logic [P-1:0] exp_p = ref_par(fr);
    chk(obits[K-1:0] == fr, "R6 R8", "information bits", 64'(obits[K-1:0]), 64'(fr));
    chk(obits[K+P-1:K] == exp_p, preq, "parity bits", 64'(obits[K+P-1:K]), 64'(exp_p));
    chk(nlast == 1 && last_pos == K + P - 1, "R6", "last marker position",
        64'(last_pos), 64'(K + P - 1));
    chk(first_out > acc_cyc[K-1], "R5", "first output after last input",
        64'(first_out), 64'(acc_cyc[K-1] + 1));
    chk(rdy_bad == 0, "R5", "input ready during output", 64'(rdy_bad), 64'd0);
    chk(hold_bad == 0, "R7", "output held under backpressure", 64'(hold_bad), 64'd0);
    if (pace) begin
      for (int r = 0; r < 3; r++) begin
        int bad = 0;
        int seen = 0;
        for (int b = 1; b < K; b++) begin
          if ((b - 1) / G == r) begin
            int d = acc_cyc[b] - acc_cyc[b-1];
            if (d != tb_len(r)) begin
              if (bad == 0) seen = d;
              bad++;
            end
          end
        end
        chk(bad == 0, "R4", $sformatf("accept interval in row %0d", r),
            64'(seen), 64'(tb_len(r)));
      end
    end
  endtask

  initial begin
    logic [K-1:0] fr;
    void'($urandom(32'd2024));
    s_valid = 1'b0; s_data = 1'b0; s_last = 1'b0; m_ready = 1'b0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(m_valid == 1'b0, "R1", "m_valid in reset", 64'(m_valid), 64'd0);
    chk(m_last == 1'b0, "R1", "m_last in reset", 64'(m_last), 64'd0);
    rst_n = 1'b1;
    #2;
    chk(m_valid == 1'b0 && s_ready == 1'b0, "R1", "idle right after reset",
        64'({m_valid, s_ready}), 64'd0);

    // Directed: all-zero frame at full rate, checks R4 pacing
    run_frame('0, 0, 0);
    check_frame('0, "R2", 1'b1);

    // Directed: single set bit at the start of group 0
    fr = '0; fr[0] = 1'b1;
    run_frame(fr, 0, 0);
    check_frame(fr, "R2", 1'b1);

    // Directed: single set bit inside the short-row group
    fr = '0; fr[2*G+3] = 1'b1;
    run_frame(fr, 0, 30);
    check_frame(fr, "R2 R9", 1'b0);

    // Directed: all ones at full rate
    fr = '1;
    run_frame(fr, 0, 0);
    check_frame(fr, "R3", 1'b1);

    // Random frames with stalls on both sides
    for (int f = 0; f < 10; f++) begin
      fr = K'({$urandom, $urandom});
      run_frame(fr, 10 + (f * 6), 10 + ((f * 7) % 60));
      check_frame(fr, "R3 R8 R9", 1'b0);
    end

    summary();
  end
endmodule